// File: doc/BRIEF.md
# DRAM Command Timing Guard

This block sits between a command scheduler and a small SDRAM device model. Each clock it looks at a single command request (activate, read, write, precharge or refresh, with rank, bank and row). It decides whether that command may go out now without breaking any of the programmed spacing rules. Spacings are given as run-time timing inputs. The write-to-precharge and write-to-read spacings are derived inside the block from CAS latency, a fixed burst of eight and the write recovery or write-to-read turnaround.

State is an open/closed flag per bank and a set of countdown counters: four per bank and three per rank. A request is granted in the same cycle it is seen if every counter it depends on is zero. A request that makes no sense for the bank state is flagged as an error and dropped. Otherwise it is stalled until it can be granted. Granted commands appear on a registered issue port one clock later.

Two optional behaviours are built in. The first is a forced auto-precharge mode that closes the row with every read or write. The second is an idle timer that precharges every open bank after a programmed number of clocks with no accepted command. A two-clock command-rate option adds a select cycle whenever the addressed rank changes.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset no bank is open, every counter is zero and no command is issued; the first ACTIVATE is granted in the cycle it is requested.
- R2: A READ or WRITE to a bank is granted no earlier than t_rcd cycles after that bank's ACTIVATE was granted.
- R3: An ACTIVATE is granted no earlier than t_rp cycles after a PRECHARGE to the same rank, and no earlier than t_rfc cycles after a REFRESH to that rank; REFRESH itself waits for t_rp.
- R4: A PRECHARGE to a bank waits at least t_ras cycles after its ACTIVATE, and ACTIVATEs to the same bank are at least t_ras + t_rp cycles apart.
- R5: After a WRITE, a PRECHARGE to that bank waits t_cl + 3 + t_wr cycles and a READ to that bank waits t_cl + 3 + t_wtr cycles (CAS latency minus one plus half of a burst of 8).
- R6: ACTIVATEs within one rank are t_rrd apart, PRECHARGEs within one rank are t_ptp apart, a PRECHARGE waits t_rtp after a READ to its bank, and a WRITE waits t_rtw after a READ in its rank.
- R7: With force_ap set, a granted READ or WRITE carries iss_auto_pre = 1 and closes the bank. That bank's next ACTIVATE waits t_rtp + t_rp cycles after the READ or t_cl + 3 + t_wr + t_rp cycles after the WRITE.
- R8: With idle_limit = L > 0, if no command is granted for L cycles while a bank is open, the block issues a precharge-all (iss_cmd = 6) L + 1 cycles after the last grant and closes every bank.
- R9: A counter loaded while still running keeps the larger of its remaining and new value, so the longest pending constraint always wins.
- R10: A READ, WRITE or PRECHARGE to a closed bank, an ACTIVATE to an open bank, or a REFRESH to a rank with an open bank raises req_err, is not issued and leaves the bank state unchanged.
- R11: With cmd_rate_2t set, a request whose rank differs from the last selected rank is stalled one extra cycle before it may be granted; a request to the same rank is not.
- R12: A grant makes iss_valid high on the next cycle with iss_cmd, iss_rank, iss_bank and iss_row equal to the request; command codes are NOP 0, ACTIVATE 1, READ 2, WRITE 3, PRECHARGE 4, REFRESH 5, precharge-all 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request present |
| req_cmd | input | 3 | Requested command code |
| req_rank | input | RK_W | Requested rank |
| req_bank | input | BK_W | Requested bank within the rank |
| req_row | input | ROW_W | Row address, passed to the issue port |
| t_rcd | input | TW | Activate to read/write spacing |
| t_rp | input | TW | Precharge to activate spacing |
| t_ras | input | TW | Minimum active time |
| t_rrd | input | TW | Activate to activate spacing within a rank |
| t_ptp | input | TW | Precharge to precharge spacing within a rank |
| t_rtp | input | TW | Read to precharge spacing |
| t_rtw | input | TW | Read to write spacing within a rank |
| t_cl | input | TW | CAS latency |
| t_wr | input | TW | Write recovery |
| t_wtr | input | TW | Internal write to read turnaround |
| t_rfc | input | TW | Refresh to activate spacing |
| idle_limit | input | IDLE_W | Idle cycles before precharge-all, 0 disables |
| force_ap | input | 1 | Force auto-precharge on reads and writes |
| cmd_rate_2t | input | 1 | Two-clock command rate |
| req_grant | output | 1 | Request accepted this cycle |
| req_stall | output | 1 | Request legal but held by timing or selection |
| req_err | output | 1 | Request illegal for the current bank state |
| iss_valid | output | 1 | Issued command valid |
| iss_cmd | output | 3 | Issued command code |
| iss_rank | output | RK_W | Issued rank |
| iss_bank | output | BK_W | Issued bank |
| iss_row | output | ROW_W | Issued row |
| iss_auto_pre | output | 1 | Issued read or write closes its row |

## Verification
The hardest situation to reach from the ports is a command held by several overlapping constraints at once. One example is a precharge that must satisfy the active time, a read-to-precharge gap and a write recovery window, all started at different cycles. The bench creates this with random timing sets from a fixed seed. Each set drives a dense activate, read, write, read, precharge, activate, refresh sequence with every request held until granted. The earliest legal cycle is computed as the maximum over every pending rule. Directed cases then cover the idle-timer precharge-all, auto-precharge reopening, the rank-change select cycle and the illegal commands.

// File: rtl/dg_pkg.sv
package dg_pkg;
   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_REF  = 3'd5,
      CMD_PREA = 3'd6
   } dg_cmd_e;

   localparam int BURST_LEN = 8;
   // CAS latency minus one plus half a burst
   localparam int WR_BASE   = BURST_LEN / 2 - 1;
endpackage

// File: rtl/dg_cnt.sv
module dg_cnt #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt_q, dec, nxt;

   assign zero = (cnt_q == '0);
   assign dec  = zero ? '0 : cnt_q - 1'b1;
   assign nxt  = (ld && (val > dec)) ? val : dec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;
   end

   a_r9_keep_max: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt_q >= $past(val)));
   a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dg_idle.sv
module dg_idle #(
   parameter int IW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          clr,
   input  logic [IW-1:0] limit,
   output logic          hit
);
   logic [IW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (busy || clr)    cnt_q <= '0;
      else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
   end

   assign hit = (limit != '0) && (cnt_q >= limit);

   a_r8_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || clr) |=> (cnt_q == '0));
endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard #(
   parameter int NUM_RANKS = 2,
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int TW        = 5,
   parameter int IDLE_W    = 10,
   localparam int RK_W     = $clog2(NUM_RANKS),
   localparam int BK_W     = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_cmd,
   input  logic [RK_W-1:0]   req_rank,
   input  logic [BK_W-1:0]   req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [TW-1:0]     t_rcd,
   input  logic [TW-1:0]     t_rp,
   input  logic [TW-1:0]     t_ras,
   input  logic [TW-1:0]     t_rrd,
   input  logic [TW-1:0]     t_ptp,
   input  logic [TW-1:0]     t_rtp,
   input  logic [TW-1:0]     t_rtw,
   input  logic [TW-1:0]     t_cl,
   input  logic [TW-1:0]     t_wr,
   input  logic [TW-1:0]     t_wtr,
   input  logic [TW-1:0]     t_rfc,
   input  logic [IDLE_W-1:0] idle_limit,
   input  logic              force_ap,
   input  logic              cmd_rate_2t,
   output logic              req_grant,
   output logic              req_stall,
   output logic              req_err,
   output logic              iss_valid,
   output logic [2:0]        iss_cmd,
   output logic [RK_W-1:0]   iss_rank,
   output logic [BK_W-1:0]   iss_bank,
   output logic [ROW_W-1:0]  iss_row,
   output logic              iss_auto_pre
);
   import dg_pkg::*;

   localparam int IDX_W  = RK_W + BK_W;
   localparam int NB_ALL = NUM_RANKS * NUM_BANKS;
   localparam int CW     = TW + 2;

   if (NUM_RANKS < 2 || (1 << RK_W) != NUM_RANKS) begin : g_bad_ranks
      $error("NUM_RANKS must be a power of two of at least 2");
   end
   if (NUM_BANKS < 2 || (1 << BK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (TW < 2 || IDLE_W < 2) begin : g_bad_widths
      $error("timing and idle widths too narrow");
   end

   // spacing S allows the next command S cycles after the grant: load S-1
   function automatic logic [CW-1:0] ld_of(input logic [CW-1:0] s);
      return (s == '0) ? '0 : s - 1'b1;
   endfunction

   dg_cmd_e cmd;
   logic [IDX_W-1:0] bi;
   logic [CW-1:0] sp_rc, sp_wtp, sp_wtr, sp_rtp_rp, sp_wtp_rp;
   logic [NB_ALL-1:0] open_q, z_rw, z_pre, z_act, z_rd, pre_blk;
   logic [NUM_RANKS-1:0] rank_open, zr_act, zr_pre, zr_wr;
   logic ok, err, cs_hold, pa_fire, idle_hit, cs_vld_q;
   logic [RK_W-1:0] cs_rank_q;

   assign cmd = dg_cmd_e'(req_cmd);
   assign bi  = {req_rank, req_bank};

   assign sp_rc     = CW'(t_ras) + CW'(t_rp);
   assign sp_wtp    = CW'(t_cl) + CW'(t_wr) + CW'(WR_BASE);
   assign sp_wtr    = CW'(t_cl) + CW'(t_wtr) + CW'(WR_BASE);
   assign sp_rtp_rp = CW'(t_rtp) + CW'(t_rp);
   assign sp_wtp_rp = sp_wtp + CW'(t_rp);

   // per-bank constraint counters
   for (genvar g = 0; g < NB_ALL; g++) begin : g_bank
      logic sel, g_act, g_rd, g_wr, ld_pre, ld_act;
      logic [CW-1:0] v_pre, v_act;
      assign sel    = (bi == IDX_W'(g));
      assign g_act  = req_grant && sel && (cmd == CMD_ACT);
      assign g_rd   = req_grant && sel && (cmd == CMD_RD);
      assign g_wr   = req_grant && sel && (cmd == CMD_WR);
      assign ld_pre = g_act || g_rd || g_wr;
      assign v_pre  = g_act ? ld_of(CW'(t_ras)) : g_rd ? ld_of(CW'(t_rtp)) : ld_of(sp_wtp);
      assign ld_act = g_act || (force_ap && (g_rd || g_wr));
      assign v_act  = g_act ? ld_of(sp_rc) : g_rd ? ld_of(sp_rtp_rp) : ld_of(sp_wtp_rp);
      assign pre_blk[g] = open_q[g] && !z_pre[g];

      dg_cnt #(.W(CW)) u_rw  (.clk(clk), .rst_n(rst_n), .ld(g_act),  .val(ld_of(CW'(t_rcd))), .zero(z_rw[g]));
      dg_cnt #(.W(CW)) u_pre (.clk(clk), .rst_n(rst_n), .ld(ld_pre), .val(v_pre),             .zero(z_pre[g]));
      dg_cnt #(.W(CW)) u_act (.clk(clk), .rst_n(rst_n), .ld(ld_act), .val(v_act),             .zero(z_act[g]));
      dg_cnt #(.W(CW)) u_rd  (.clk(clk), .rst_n(rst_n), .ld(g_wr),   .val(ld_of(sp_wtr)),     .zero(z_rd[g]));
   end

   // per-rank constraint counters
   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      logic selr, ld_act;
      logic [CW-1:0] v_act;
      assign rank_open[r] = |open_q[r*NUM_BANKS +: NUM_BANKS];
      assign selr   = req_grant && (req_rank == RK_W'(r));
      assign ld_act = (pa_fire && rank_open[r]) ||
                      (selr && (cmd == CMD_ACT || cmd == CMD_PRE || cmd == CMD_REF));
      assign v_act  = (pa_fire || cmd == CMD_PRE) ? ld_of(CW'(t_rp)) :
                      (cmd == CMD_ACT) ? ld_of(CW'(t_rrd)) : ld_of(CW'(t_rfc));

      dg_cnt #(.W(CW)) u_act (.clk(clk), .rst_n(rst_n), .ld(ld_act), .val(v_act), .zero(zr_act[r]));
      dg_cnt #(.W(CW)) u_pre (.clk(clk), .rst_n(rst_n), .ld(selr && cmd == CMD_PRE),
                              .val(ld_of(CW'(t_ptp))), .zero(zr_pre[r]));
      dg_cnt #(.W(CW)) u_wr  (.clk(clk), .rst_n(rst_n), .ld(selr && cmd == CMD_RD),
                              .val(ld_of(CW'(t_rtw))), .zero(zr_wr[r]));
   end

   // legality and readiness of the current request
   always_comb begin
      ok  = 1'b0;
      err = 1'b0;
      unique case (cmd)
         CMD_ACT: begin err = open_q[bi];  ok = z_act[bi] && zr_act[req_rank]; end
         CMD_RD:  begin err = !open_q[bi]; ok = z_rw[bi] && z_rd[bi]; end
         CMD_WR:  begin err = !open_q[bi]; ok = z_rw[bi] && zr_wr[req_rank]; end
         CMD_PRE: begin err = !open_q[bi]; ok = z_pre[bi] && zr_pre[req_rank]; end
         CMD_REF: begin err = rank_open[req_rank]; ok = zr_act[req_rank]; end
         default: err = 1'b1;
      endcase
   end

   assign cs_hold   = cmd_rate_2t && (!cs_vld_q || cs_rank_q != req_rank);
   assign pa_fire   = idle_hit && (|open_q) && !(|pre_blk);
   assign req_err   = req_valid && err;
   assign req_grant = req_valid && !err && ok && !cs_hold && !pa_fire;
   assign req_stall = req_valid && !err && !req_grant;

   dg_idle #(.IW(IDLE_W)) u_idle (
      .clk(clk), .rst_n(rst_n), .busy(req_grant), .clr(pa_fire),
      .limit(idle_limit), .hit(idle_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q    <= '0;
         cs_vld_q  <= 1'b0;
         cs_rank_q <= '0;
      end else begin
         if (req_valid && !err) begin
            cs_vld_q  <= 1'b1;
            cs_rank_q <= req_rank;
         end
         if (pa_fire) open_q <= '0;
         else if (req_grant) begin
            if (cmd == CMD_ACT) open_q[bi] <= 1'b1;
            else if (cmd == CMD_PRE || (force_ap && (cmd == CMD_RD || cmd == CMD_WR)))
               open_q[bi] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iss_valid    <= 1'b0;
         iss_cmd      <= CMD_NOP;
         iss_rank     <= '0;
         iss_bank     <= '0;
         iss_row      <= '0;
         iss_auto_pre <= 1'b0;
      end else begin
         iss_valid    <= req_grant || pa_fire;
         iss_cmd      <= pa_fire ? CMD_PREA : (req_grant ? req_cmd : CMD_NOP);
         iss_rank     <= pa_fire ? '0 : req_rank;
         iss_bank     <= pa_fire ? '0 : req_bank;
         iss_row      <= pa_fire ? '0 : req_row;
         iss_auto_pre <= req_grant && force_ap && (cmd == CMD_RD || cmd == CMD_WR);
      end
   end

   a_r10_err_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> !req_grant);
   a_r10_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (req_err && !pa_fire) |=> (open_q == $past(open_q)));
   a_r12_issue_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant |=> (iss_valid && iss_cmd == $past(req_cmd) && iss_bank == $past(req_bank)));
   a_r8_prea_closes_all: assert property (@(posedge clk) disable iff (!rst_n)
      pa_fire |=> (open_q == '0 && iss_cmd == CMD_PREA));
   a_r4_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant && cmd == CMD_ACT) |=> open_q[$past(bi)]);
   a_r11_select_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rate_2t && req_valid && !cs_vld_q) |-> !req_grant);
endmodule

// File: tb/test_dram_cmd_guard.sv
`timescale 1ns/1ps
module test_dram_cmd_guard;
   localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                          C_PRE = 3'd4, C_REF = 3'd5, C_PREA = 3'd6;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, req_valid, force_ap, cmd_rate_2t;
   logic [2:0]  req_cmd;
   logic        req_rank;
   logic [1:0]  req_bank;
   logic [11:0] req_row;
   logic [4:0]  t_rcd, t_rp, t_ras, t_rrd, t_ptp, t_rtp, t_rtw, t_cl, t_wr, t_wtr, t_rfc;
   logic [9:0]  idle_limit;
   logic        req_grant, req_stall, req_err, iss_valid, iss_auto_pre;
   logic [2:0]  iss_cmd;
   logic        iss_rank;
   logic [1:0]  iss_bank;
   logic [11:0] iss_row;

   dram_cmd_guard i_dram_cmd_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_rank(req_rank), .req_bank(req_bank), .req_row(req_row),
      .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_rrd(t_rrd), .t_ptp(t_ptp),
      .t_rtp(t_rtp), .t_rtw(t_rtw), .t_cl(t_cl), .t_wr(t_wr), .t_wtr(t_wtr),
      .t_rfc(t_rfc), .idle_limit(idle_limit), .force_ap(force_ap),
      .cmd_rate_2t(cmd_rate_2t), .req_grant(req_grant), .req_stall(req_stall),
      .req_err(req_err), .iss_valid(iss_valid), .iss_cmd(iss_cmd),
      .iss_rank(iss_rank), .iss_bank(iss_bank), .iss_row(iss_row),
      .iss_auto_pre(iss_auto_pre)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0, bad = 0, last_ts = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // hold a request until granted; check issue port; return grant cycle
   task automatic issue(input logic [2:0] c, input int rk, input int bk,
                        input int exp, input string tag, output int tg);
      bit got = 0;
      @(negedge clk);
      req_valid = 1'b1; req_cmd = c; req_rank = rk[0]; req_bank = bk[1:0];
      req_row = 12'(rk * 100 + bk * 7 + c);
      last_ts = cyc;
      tg = -1;
      for (int k = 0; k < 300; k++) begin
         #1;
         if (req_grant) begin tg = cyc; got = 1; break; end
         if (req_err) break;
         @(negedge clk);
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
      if (!got) chk(0, tag, req_err, 0);
      else begin
         chk(iss_valid && iss_cmd == c && iss_rank == rk[0] && iss_bank == bk[1:0] &&
             iss_row == 12'(rk * 100 + bk * 7 + c), "R12", iss_cmd, c);
         chk(iss_auto_pre == (force_ap && (c == C_RD || c == C_WR)), "R12", iss_auto_pre,
             force_ap && (c == C_RD || c == C_WR));
         if (exp >= 0) chk(tg == exp, tag, tg, exp);
      end
   endtask

   task automatic expect_err(input logic [2:0] c, input int rk, input int bk, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_cmd = c; req_rank = rk[0]; req_bank = bk[1:0]; req_row = '0;
      #1;
      chk(req_err && !req_grant && !req_stall, tag, req_err, 1);
      @(posedge clk); #1;
      req_valid = 1'b0;
      chk(!iss_valid, tag, iss_valid, 0);
   endtask

   task automatic set_all(input int v);
      t_rcd = 5'(v); t_rp = 5'(v); t_ras = 5'(v); t_rrd = 5'(v); t_ptp = 5'(v);
      t_rtp = 5'(v); t_rtw = 5'(v); t_wr = 5'(v); t_wtr = 5'(v); t_rfc = 5'(v);
      t_cl = 5'(v);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", cyc, 200000);
      finish_run();
   end

   initial begin
      int ta, tr, tw, tr2, tp, ta2, ta3, tp0, tp1, tf, tx, e;
      int rcd, rp, ras, rrd, ptp, rtp, rtw, cl, wr, wtr, rfc, wtp, wtrs, rk;
      int unsigned seed;
      seed = $urandom(32'd4242);
      rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_rank = '0; req_bank = '0;
      req_row = '0; force_ap = 1'b0; cmd_rate_2t = 1'b0; idle_limit = '0;
      set_all(2);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state and immediate first activate
      @(negedge clk);
      chk(!iss_valid && !req_grant && !req_err, "R1", iss_valid, 0);
      issue(C_ACT, 0, 0, -1, "R1", ta);
      chk(ta == last_ts, "R1", ta, last_ts);
      issue(C_PRE, 0, 0, -1, "R4", tp);
      repeat (40) @(posedge clk);

      // random timing sets, constraints overlapping
      for (int it = 0; it < 12; it++) begin
         rcd = 1 + $urandom % 8; rp = 1 + $urandom % 8; ras = 1 + $urandom % 8;
         rrd = 1 + $urandom % 8; ptp = 1 + $urandom % 8; rtp = 1 + $urandom % 8;
         rtw = 1 + $urandom % 8; cl = 2 + $urandom % 5; wr = 1 + $urandom % 6;
         wtr = 1 + $urandom % 6; rfc = 4 + $urandom % 13; rk = $urandom % 2;
         t_rcd = 5'(rcd); t_rp = 5'(rp); t_ras = 5'(ras); t_rrd = 5'(rrd);
         t_ptp = 5'(ptp); t_rtp = 5'(rtp); t_rtw = 5'(rtw); t_cl = 5'(cl);
         t_wr = 5'(wr); t_wtr = 5'(wtr); t_rfc = 5'(rfc);
         wtp = cl + 3 + wr; wtrs = cl + 3 + wtr;
         issue(C_ACT, rk, 0, -1, "R1", ta);
         issue(C_RD, rk, 0, mx(ta + rcd, ta + 1), "R2", tr);
         issue(C_WR, rk, 0, mx(tr + rtw, tr + 1), "R6", tw);
         issue(C_RD, rk, 0, mx(tw + wtrs, tw + 1), "R5", tr2);
         e = mx(mx(ta + ras, tr2 + rtp), mx(tw + wtp, tr2 + 1));
         issue(C_PRE, rk, 0, e, "R5", tp);
         issue(C_ACT, rk, 0, mx(mx(tp + rp, ta + ras + rp), tp + 1), "R4", ta2);
         issue(C_ACT, rk, 1, mx(ta2 + rrd, ta2 + 1), "R6", ta3);
         issue(C_PRE, rk, 0, mx(mx(ta2 + ras, tp + ptp), ta3 + 1), "R6", tp0);
         issue(C_PRE, rk, 1, mx(mx(ta3 + ras, tp0 + ptp), tp0 + 1), "R6", tp1);
         e = mx(mx(tp0 + rp, tp1 + rp), mx(ta3 + rrd, tp1 + 1));
         issue(C_REF, rk, 0, e, "R3", tf);
         issue(C_ACT, rk, 2, mx(tf + rfc, tf + 1), "R3", tx);
         issue(C_PRE, rk, 2, -1, "R4", tx);
         repeat (40) @(posedge clk);
      end

      // R9: long active time dominates a short read-to-precharge
      set_all(1); t_ras = 5'd12; t_rtp = 5'd2; t_cl = 5'd2;
      issue(C_ACT, 0, 2, -1, "R9", ta);
      issue(C_RD, 0, 2, ta + 1, "R2", tr);
      issue(C_PRE, 0, 2, ta + 12, "R9", tp);

      // R10: illegal commands are dropped, state untouched
      expect_err(C_WR, 0, 2, "R10");
      expect_err(C_PRE, 0, 2, "R10");
      issue(C_ACT, 0, 2, -1, "R10", ta);
      expect_err(C_ACT, 0, 2, "R10");
      expect_err(C_REF, 0, 0, "R10");
      expect_err(3'd0, 0, 2, "R10");
      issue(C_RD, 0, 2, -1, "R10", tr);
      issue(C_PRE, 0, 2, -1, "R10", tp);
      repeat (20) @(posedge clk);

      // R7: forced auto-precharge
      set_all(2); t_rcd = 5'd2; t_ras = 5'd4; t_rp = 5'd3; t_rtp = 5'd3;
      t_cl = 5'd3; t_wr = 5'd2;
      force_ap = 1'b1;
      issue(C_ACT, 1, 3, -1, "R7", ta);
      issue(C_RD, 1, 3, ta + 2, "R2", tr);
      expect_err(C_WR, 1, 3, "R7");
      issue(C_ACT, 1, 3, mx(tr + 3 + 3, ta + 4 + 3), "R7", ta);
      issue(C_WR, 1, 3, ta + 2, "R2", tw);
      expect_err(C_RD, 1, 3, "R7");
      issue(C_ACT, 1, 3, mx(tw + (3 + 3 + 2) + 3, ta + 7), "R7", ta);
      force_ap = 1'b0;
      issue(C_PRE, 1, 3, -1, "R4", tp);
      repeat (20) @(posedge clk);

      // R8: idle timer precharge-all
      set_all(2);
      idle_limit = 10'd6;
      issue(C_ACT, 0, 1, -1, "R8", ta);
      issue(C_ACT, 1, 2, -1, "R8", ta);
      tx = -1;
      for (int k = 0; k < 60; k++) begin
         if (iss_valid && iss_cmd == C_PREA) begin tx = cyc; break; end
         @(posedge clk); #1;
      end
      chk(tx == ta + 6 + 2, "R8", tx, ta + 8);
      idle_limit = '0;
      expect_err(C_RD, 0, 1, "R8");
      expect_err(C_PRE, 1, 2, "R8");
      repeat (10) @(posedge clk);

      // R11: two-clock command rate select cycle on rank change
      set_all(1);
      cmd_rate_2t = 1'b1;
      issue(C_ACT, 0, 1, -1, "R11", ta);
      issue(C_ACT, 1, 1, -1, "R11", ta);
      chk(ta == last_ts + 1, "R11", ta, last_ts + 1);
      issue(C_RD, 1, 1, -1, "R11", tr);
      chk(tr == last_ts, "R11", tr, last_ts);
      issue(C_PRE, 0, 1, -1, "R11", tp);
      chk(tp == last_ts + 1, "R11", tp, last_ts + 1);
      cmd_rate_2t = 1'b0;
      issue(C_PRE, 1, 1, -1, "R11", tp);
      chk(tp == last_ts, "R11", tp, last_ts);

      repeat (5) @(posedge clk);
      finish_run();
   end
endmodule